// File: doc/BRIEF.md
# Dual-Port RAM with Clearable Read Output

This block is a simple dual-port synchronous RAM: one write port and one read port share a single clock and a single clock enable. The word width and the address width are parameters. The read data comes from an output latch. A parameter can add an output register behind that latch, which adds one cycle of read latency. Every input is captured in an input register before it is used. A write therefore lands in the array one enabled edge after it is presented. The read address is looked up from its register.

An active-high asynchronous clear, `out_clear`, acts only on the read side. It forces the output latch, the optional output register and the registered read address (with its read-valid bit) to zero. The stored words are never cleared. The write-side input registers are never cleared, so a write that is already registered still commits while clear is held. Once cleared, the output stays zero until a new read has completed. That read must be presented with `clk_en` and `rd_en` high at a rising edge after clear has dropped.

A small state machine tracks read-side recovery:
- CLEAR is entered asynchronously whenever clear is asserted.
- CLEAR moves to FETCH on the first enabled edge that captures a read.
- FETCH moves to LIVE on the next enabled edge, when the latch loads the word.
- LIVE holds until the next clear.

Top module: `clr_dpram`

## Requirements
- R1: With `wr_en` high at a rising edge where `clk_en` is high, `wr_data` is stored at `wr_addr` on the next enabled edge. A later read of that address returns it.
- R2: A read is presented as `rd_en` high with `rd_addr` at an enabled edge E1. With `OUT_REG`=1, `rd_data` shows the word after the third enabled edge counted from E1, and keeps its previous value after E1 and E2. With `OUT_REG`=0 the word appears after E2.
- R3: While `out_clear` is high, `rd_data` is zero and the registered read address is zero, with no clock edge needed.
- R4: After clear is released, `rd_data` stays zero through any number of edges, enabled or not, until a read presented after the release completes. That read returns the correct stored word.
- R5: An edge with `clk_en` low changes nothing: no write is captured, no read is captured, and a cleared output is not released.
- R6: Clear modifies no stored word. A write registered before clear is asserted still commits while clear is held.
- R7: A read and a write to the same address registered at the same edge return the word held before the write. The new word is returned by a later read.
- R8: While `rd_en` is low, `rd_data` keeps its value even if `rd_addr` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports and the output stage |
| clk_en | input | 1 | Clock enable for every register in the block |
| out_clear | input | 1 | Active-high asynchronous clear of the read output and read address |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request; also gates updates of the output stage |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data from the output latch or output register |

## Verification
Two pairs of operations can land on the same clock edge. In the first pair, the array write and the latch's lookup hit the same word: the bench presents a write and a read to one address in the same cycle and expects the old word, then reads again and expects the new one. In the second pair, a registered write commits while clear is held: the bench raises clear in the middle of the cycle after presenting a write. It expects zero on the output at once and through disabled and idle edges, and then the written word from the first enabled read.

// File: rtl/clr_dpram_pkg.sv
package clr_dpram_pkg;

    // Read-side recovery state
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,   // output forced to zero, waiting for a read
        ST_FETCH = 2'd1,   // read captured after clear, latch loads next
        ST_LIVE  = 2'd2    // normal operation
    } rd_state_e;

endpackage

// File: rtl/clr_dpram_wr_reg.sv
module clr_dpram_wr_reg #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_en_q,
    output logic [ADDR_W-1:0] wr_addr_q,
    output logic [DATA_W-1:0] wr_data_q
);

    // Write-side input registers: deliberately outside the clear domain.
    always_ff @(posedge clk) begin
        if (clk_en) begin
            wr_en_q   <= wr_en;
            wr_addr_q <= wr_addr;
            wr_data_q <= wr_data;
        end
    end

endmodule

// File: rtl/clr_dpram_array.sv
module clr_dpram_array #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              wr_en_q,
    input  logic [ADDR_W-1:0] wr_addr_q,
    input  logic [DATA_W-1:0] wr_data_q,
    input  logic [ADDR_W-1:0] rd_addr_q,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage has no clear path at all.
    always_ff @(posedge clk) begin
        if (clk_en && wr_en_q) begin
            mem[wr_addr_q] <= wr_data_q;
        end
    end

    // Lookup of the registered address; sampled by the latch at the same
    // edge the write lands, which yields the old word on a collision.
    assign rd_word = mem[rd_addr_q];

endmodule

// File: rtl/clr_dpram_rd_ctrl.sv
module clr_dpram_rd_ctrl
    import clr_dpram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              out_clear,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              rd_load,
    output rd_state_e         rd_state
);

    logic      rd_vld_q;
    rd_state_e state_nxt;

    // Read address register and its valid bit: both cleared asynchronously.
    always_ff @(posedge clk or posedge out_clear) begin
        if (out_clear) begin
            rd_addr_q <= '0;
            rd_vld_q  <= 1'b0;
        end else if (clk_en) begin
            rd_addr_q <= rd_addr;
            rd_vld_q  <= rd_en;
        end
    end

    // State register
    always_ff @(posedge clk or posedge out_clear) begin
        if (out_clear) begin
            rd_state <= ST_CLEAR;
        end else begin
            rd_state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = rd_state;
        unique case (rd_state)
            ST_CLEAR: if (clk_en && rd_en) state_nxt = ST_FETCH;
            ST_FETCH: if (clk_en)          state_nxt = ST_LIVE;
            ST_LIVE:                       state_nxt = ST_LIVE;
            default:                       state_nxt = ST_CLEAR;
        endcase
    end

    // Outputs: the output latch may load only from a read captured after clear
    always_comb begin
        unique case (rd_state)
            ST_CLEAR: rd_load = 1'b0;
            ST_FETCH: rd_load = rd_vld_q;
            ST_LIVE:  rd_load = rd_vld_q;
            default:  rd_load = 1'b0;
        endcase
    end

endmodule

// File: rtl/clr_dpram_out_stage.sv
module clr_dpram_out_stage #(
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              out_clear,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] latch_q;

    // Output latch: cleared asynchronously, released only by an enabled load
    always_ff @(posedge clk or posedge out_clear) begin
        if (out_clear) begin
            latch_q <= '0;
        end else if (clk_en && rd_load) begin
            latch_q <= rd_word;
        end
    end

    generate
        if (OUT_REG) begin : g_out_reg
            logic [DATA_W-1:0] oreg_q;
            always_ff @(posedge clk or posedge out_clear) begin
                if (out_clear) begin
                    oreg_q <= '0;
                end else if (clk_en) begin
                    oreg_q <= latch_q;
                end
            end
            assign rd_data = oreg_q;
        end else begin : g_out_latch
            assign rd_data = latch_q;
        end
    endgenerate

endmodule

// File: rtl/clr_dpram.sv
module clr_dpram
    import clr_dpram_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              out_clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rd_word;
    logic              rd_load;
    rd_state_e         rd_state;

    clr_dpram_wr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_reg (
        .clk       (clk),
        .clk_en    (clk_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en_q   (wr_en_q),
        .wr_addr_q (wr_addr_q),
        .wr_data_q (wr_data_q)
    );

    clr_dpram_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd_ctrl (
        .clk       (clk),
        .clk_en    (clk_en),
        .out_clear (out_clear),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_addr_q (rd_addr_q),
        .rd_load   (rd_load),
        .rd_state  (rd_state)
    );

    clr_dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .clk_en    (clk_en),
        .wr_en_q   (wr_en_q),
        .wr_addr_q (wr_addr_q),
        .wr_data_q (wr_data_q),
        .rd_addr_q (rd_addr_q),
        .rd_word   (rd_word)
    );

    clr_dpram_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out_stage (
        .clk       (clk),
        .clk_en    (clk_en),
        .out_clear (out_clear),
        .rd_load   (rd_load),
        .rd_word   (rd_word),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/clr_dpram_chk.sv
module clr_dpram_chk
    import clr_dpram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              clk_en,
    input logic              out_clear,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] rd_addr_q,
    input rd_state_e         rd_state
);

    // Set once a read has been captured since the last clear
    logic read_seen;
    always_ff @(posedge clk or posedge out_clear) begin
        if (out_clear) begin
            read_seen <= 1'b0;
        end else if (clk_en && rd_en) begin
            read_seen <= 1'b1;
        end
    end

    always @(negedge clk) begin
        if (out_clear) begin
            assert_clear_zero_R3: assert (rd_data == '0)
                else $error("R3: read data not zero under clear");
            assert_clear_addr_R3: assert (rd_addr_q == '0)
                else $error("R3: read address not zero under clear");
        end
    end

    assert_zero_until_read_R4: assert property (@(posedge clk) disable iff (out_clear)
        !read_seen |-> rd_data == '0)
        else $error("R4: output released without a read");

    assert_wait_in_clear_R4: assert property (@(posedge clk) disable iff (out_clear)
        (rd_state == ST_CLEAR && !(clk_en && rd_en)) |=> rd_state == ST_CLEAR)
        else $error("R4: left clear state without a read");

    assert_hold_no_enable_R5: assert property (@(posedge clk) disable iff (out_clear)
        !clk_en |=> $stable(rd_data))
        else $error("R5: output changed on a disabled edge");

endmodule

bind clr_dpram clr_dpram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .clk_en    (clk_en),
    .out_clear (out_clear),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_addr_q (rd_addr_q),
    .rd_state  (rd_state)
);

// File: tb/test_clr_dpram.sv
module test_clr_dpram;

    localparam int DW  = 16;
    localparam int AW  = 5;
    localparam bit ORG = 1'b1;
    localparam int LAT = ORG ? 2 : 1;

    logic          clk = 1'b0;
    logic          clk_en;
    logic          out_clear;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    clr_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(ORG)) i_clr_dpram (
        .clk       (clk),
        .clk_en    (clk_en),
        .out_clear (out_clear),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return 16'hA001 + 16'(i) * 16'h0111;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic do_write(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] d);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        repeat (LAT) @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset;
        check("R3 reset output zero", rd_data, '0);
        out_clear = 1'b0;
        @(negedge clk);
        check("R4 zero after reset release", rd_data, '0);
    endtask

    task automatic t_fill_and_read;
        logic [DW-1:0] d;
        for (int i = 0; i < 8; i++) do_write(i, pat(i));
        for (int i = 7; i >= 0; i -= 3) begin
            do_read(i, d);
            check("R1 write then read", d, pat(i));
        end
    endtask

    task automatic t_latency;
        logic [DW-1:0] d;
        do_read(2, d);
        rd_en = 1'b1; rd_addr = AW'(6);
        @(negedge clk);
        rd_en = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            check("R2 old word before latency", rd_data, pat(2));
        end
        @(negedge clk);
        check("R2 new word at latency", rd_data, pat(6));
    endtask

    task automatic t_hold_no_rd_en;
        logic [DW-1:0] d;
        do_read(4, d);
        rd_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            rd_addr = AW'(k);
            @(negedge clk);
        end
        check("R8 hold while rd_en low", rd_data, pat(4));
    endtask

    task automatic t_collision;
        logic [DW-1:0] d;
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = 16'h5A5A;
        rd_en = 1'b1; rd_addr = AW'(3);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (LAT) @(negedge clk);
        check("R7 collision returns old word", rd_data, pat(3));
        do_read(3, d);
        check("R7 later read returns new word", d, 16'h5A5A);
    endtask

    task automatic t_clear;
        logic [DW-1:0] d;
        do_read(1, d);
        check("R1 nonzero before clear", d, pat(1));
        // write registered, then clear raised before it commits
        wr_en = 1'b1; wr_addr = AW'(5); wr_data = 16'hC3C3;
        @(negedge clk);
        wr_en = 1'b0;
        #2 out_clear = 1'b1;
        #1 check("R3 immediate zero on clear", rd_data, '0);
        @(negedge clk);
        check("R3 zero while clear held", rd_data, '0);
        out_clear = 1'b0;
        // disabled edges with a read pending must not release
        clk_en = 1'b0; rd_en = 1'b1; rd_addr = AW'(5);
        repeat (4) @(negedge clk);
        check("R5 disabled edges keep output cleared", rd_data, '0);
        // enabled edges without a read must not release
        rd_en = 1'b0; clk_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 idle edges keep output cleared", rd_data, '0);
        do_read(5, d);
        check("R4 R6 first read after clear", d, 16'hC3C3);
        do_read(2, d);
        check("R6 array kept through clear", d, pat(2));
    endtask

    task automatic t_disabled_write;
        logic [DW-1:0] d;
        clk_en = 1'b0;
        wr_en = 1'b1; wr_addr = AW'(6); wr_data = 16'hDEAD;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; clk_en = 1'b1;
        @(negedge clk);
        do_read(6, d);
        check("R5 write ignored on disabled edges", d, pat(6));
    endtask

    initial begin
        clk_en = 1'b1; out_clear = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_fill_and_read();
        t_latency();
        t_hold_no_rd_en();
        t_collision();
        t_clear();
        t_disabled_write();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule